// File: doc/BRIEF.md
# Paged Register Window Bridge

This bridge lets a narrow configuration aperture reach a much larger internal register space. Software first programs a page number into a page-select register inside the aperture. It then reads or writes a fixed 512-byte window in the same aperture. Each window access is passed on to the internal register bus at an address formed from the stored page number (upper bits) and the low nine offset bits of the access (lower bits).

The slave side is a simple register bus. A request is held (address, write data, write or read strobe) until the bridge pulses `s_ready` for one cycle. Window accesses are forwarded on a master port whose request is held until the internal side answers with `m_ready`. Page-register accesses and accesses that decode to nothing complete locally. A decode miss is reported on `s_miss` together with zero read data.

Top module: `paged_reg_window`

## Requirements
- R1: After reset the stored page is zero, `m_req` is low and `s_ready` is low; a first read of the page-select register returns 0.
- R2: The page-select register is at aperture byte address 0x41C. A write stores `s_wdata[22:0]`. A read returns the stored 23-bit page zero-extended to 32 bits, so upper write-data bits read back as zero.
- R3: A write inside the window drives `m_we`=1, `m_wdata`=`s_wdata`, and `m_addr` = {page, `s_addr[8:0]`} (page in bits 31:9, offset in bits 8:0).
- R4: A read inside the window drives `m_we`=0 and `m_addr` = {page, `s_addr[8:0]`}, and returns the internal `m_rdata` on `s_rdata`. A window write returns 0 on `s_rdata`.
- R5: The window covers aperture byte addresses 0x800 to 0x9FF inclusive. 0x800 and 0x9FC are forwarded; 0x7FC and 0xA00 are not.
- R6: Any address other than exactly 0x41C or the window is a decode miss. It completes with `s_miss`=1 and `s_rdata`=0, never raises `m_req`, and a write to it leaves the stored page unchanged.
- R7: A forwarded request keeps `m_req`, `m_addr`, `m_we` and `m_wdata` stable until `m_ready`. `s_ready` stays low meanwhile. `s_ready` rises the cycle after `m_ready` is sampled, so a window access with L wait cycles on the internal side takes 2+L cycles.
- R8: Page-register and miss accesses complete with `s_ready` one cycle after the request is sampled, with no internal-bus activity. `s_ready` is always a single-cycle pulse, and `s_miss` is 0 for every hit.
- R9: A page change affects only window accesses that are issued after the page write has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| s_addr | input | 12 | Aperture byte address |
| s_wdata | input | 32 | Slave write data |
| s_we | input | 1 | Slave write strobe, held until `s_ready` |
| s_re | input | 1 | Slave read strobe, held until `s_ready` |
| s_rdata | output | 32 | Slave read data, valid with `s_ready` |
| s_ready | output | 1 | One-cycle completion pulse |
| s_miss | output | 1 | Decode miss, valid with `s_ready` |
| m_req | output | 1 | Internal request, held until `m_ready` |
| m_we | output | 1 | Internal write (1) or read (0) |
| m_addr | output | 32 | Internal address {page, offset} |
| m_wdata | output | 32 | Internal write data |
| m_rdata | input | 32 | Internal read data, valid with `m_ready` |
| m_ready | input | 1 | Internal completion |

## Verification
The address path is exercised with random pages and random offsets across the whole window, which separates a correct {page, offset} join from one that drops or shifts bits. Directed accesses at both window edges and their immediate neighbours, plus 0x41D, isolate off-by-one errors in the decode. Random internal wait times from zero to three cycles tell a bridge that holds its request and stalls the slave apart from one that completes early. Page writes with all-ones data, and page writes mixed between window accesses, show both the 23-bit masking and that a new page applies only to later accesses.

// File: rtl/win_pkg.sv
package win_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FWD  = 2'd1,
    ST_DONE = 2'd2
  } xfer_state_e;

  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_PAGE = 2'd1,
    HIT_WIN  = 2'd2
  } hit_e;
endpackage

// File: rtl/win_rst_sync.sv
module win_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/win_addr_decode.sv
module win_addr_decode
  import win_pkg::*;
#(
  parameter int              CFG_AW       = 12,
  parameter int              OFS_W        = 9,
  parameter logic [CFG_AW-1:0] PAGE_SEL_OFS = 12'h41C,
  parameter logic [CFG_AW-1:0] WIN_BASE     = 12'h800
) (
  input  logic [CFG_AW-1:0] addr,
  output hit_e              hit
);
  localparam int TAG_W = CFG_AW - OFS_W;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[CFG_AW-1:OFS_W];

  logic page_match;
  logic win_match;

  assign page_match = (addr == PAGE_SEL_OFS);
  assign win_match  = (addr[CFG_AW-1:OFS_W] == WIN_TAG);

  always_comb begin
    if (page_match)     hit = HIT_PAGE;
    else if (win_match) hit = HIT_WIN;
    else                hit = HIT_NONE;
  end
endmodule

// File: rtl/win_page_reg.sv
module win_page_reg #(
  parameter int PAGE_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_page,
  output logic [PAGE_W-1:0] page
);
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     page_q <= '0;
    else if (wr_en) page_q <= wr_page;
  end

  assign page = page_q;
endmodule

// File: rtl/win_xfer_ctrl.sv
module win_xfer_ctrl
  import win_pkg::*;
#(
  parameter int DW     = 32,
  parameter int OFS_W  = 9,
  parameter int PAGE_W = 23,
  localparam int IAW   = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  hit_e              hit,
  input  logic [DW-1:0]     wdata,
  input  logic [OFS_W-1:0]  offset,
  input  logic [PAGE_W-1:0] page,
  output logic              page_wr_en,
  output logic              m_req,
  output logic              m_we,
  output logic [IAW-1:0]    m_addr,
  output logic [DW-1:0]     m_wdata,
  input  logic [DW-1:0]     m_rdata,
  input  logic              m_ready,
  output logic [DW-1:0]     s_rdata,
  output logic              s_ready,
  output logic              s_miss
);
  xfer_state_e        state_q, state_d;
  logic               mreq_q, mreq_d;
  logic               mwe_q, mwe_d;
  logic [IAW-1:0]     maddr_q, maddr_d;
  logic [DW-1:0]      mwdata_q, mwdata_d;
  logic [DW-1:0]      rdata_q, rdata_d;
  logic               miss_q, miss_d;
  logic               load_fwd;

  always_comb begin
    state_d    = state_q;
    mreq_d     = mreq_q;
    mwe_d      = mwe_q;
    maddr_d    = maddr_q;
    mwdata_d   = mwdata_q;
    rdata_d    = rdata_q;
    miss_d     = miss_q;
    page_wr_en = 1'b0;
    load_fwd   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          unique case (hit)
            HIT_PAGE: begin
              page_wr_en = we;
              rdata_d    = we ? '0 : {{(DW-PAGE_W){1'b0}}, page};
              miss_d     = 1'b0;
              state_d    = ST_DONE;
            end
            HIT_WIN: begin
              load_fwd = 1'b1;
              mreq_d   = 1'b1;
              mwe_d    = we;
              maddr_d  = {page, offset};
              mwdata_d = wdata;
              miss_d   = 1'b0;
              state_d  = ST_FWD;
            end
            default: begin
              rdata_d = '0;
              miss_d  = 1'b1;
              state_d = ST_DONE;
            end
          endcase
        end
      end
      ST_FWD: begin
        if (m_ready) begin
          mreq_d  = 1'b0;
          rdata_d = mwe_q ? '0 : m_rdata;
          state_d = ST_DONE;
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
        mreq_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mreq_q  <= 1'b0;
      rdata_q <= '0;
      miss_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mreq_q  <= mreq_d;
      rdata_q <= rdata_d;
      miss_q  <= miss_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mwe_q    <= 1'b0;
      maddr_q  <= '0;
      mwdata_q <= '0;
    end else if (load_fwd) begin
      mwe_q    <= mwe_d;
      maddr_q  <= maddr_d;
      mwdata_q <= mwdata_d;
    end
  end

  assign m_req   = mreq_q;
  assign m_we    = mwe_q;
  assign m_addr  = maddr_q;
  assign m_wdata = mwdata_q;
  assign s_ready = (state_q == ST_DONE);
  assign s_rdata = rdata_q;
  assign s_miss  = miss_q;
endmodule

// File: rtl/paged_reg_window.sv
module paged_reg_window
  import win_pkg::*;
#(
  parameter int                DW           = 32,
  parameter int                CFG_AW       = 12,
  parameter int                OFS_W        = 9,
  parameter int                PAGE_W       = 23,
  parameter logic [CFG_AW-1:0] PAGE_SEL_OFS = 12'h41C,
  parameter logic [CFG_AW-1:0] WIN_BASE     = 12'h800,
  localparam int               IAW          = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_AW-1:0] s_addr,
  input  logic [DW-1:0]     s_wdata,
  input  logic              s_we,
  input  logic              s_re,
  output logic [DW-1:0]     s_rdata,
  output logic              s_ready,
  output logic              s_miss,
  output logic              m_req,
  output logic              m_we,
  output logic [IAW-1:0]    m_addr,
  output logic [DW-1:0]     m_wdata,
  input  logic [DW-1:0]     m_rdata,
  input  logic              m_ready
);
  logic              rst_n_int;
  hit_e              hit;
  logic              page_wr_en;
  logic [PAGE_W-1:0] page;

  win_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  win_addr_decode #(
    .CFG_AW       (CFG_AW),
    .OFS_W        (OFS_W),
    .PAGE_SEL_OFS (PAGE_SEL_OFS),
    .WIN_BASE     (WIN_BASE)
  ) u_dec (
    .addr (s_addr),
    .hit  (hit)
  );

  win_page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (page_wr_en),
    .wr_page (s_wdata[PAGE_W-1:0]),
    .page    (page)
  );

  win_xfer_ctrl #(
    .DW     (DW),
    .OFS_W  (OFS_W),
    .PAGE_W (PAGE_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .req        (s_we | s_re),
    .we         (s_we),
    .hit        (hit),
    .wdata      (s_wdata),
    .offset     (s_addr[OFS_W-1:0]),
    .page       (page),
    .page_wr_en (page_wr_en),
    .m_req      (m_req),
    .m_we       (m_we),
    .m_addr     (m_addr),
    .m_wdata    (m_wdata),
    .m_rdata    (m_rdata),
    .m_ready    (m_ready),
    .s_rdata    (s_rdata),
    .s_ready    (s_ready),
    .s_miss     (s_miss)
  );
endmodule

// File: rtl/win_checker.sv
module win_checker #(
  parameter int DW     = 32,
  parameter int CFG_AW = 12,
  parameter int OFS_W  = 9,
  parameter int IAW    = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CFG_AW-1:0] s_addr,
  input logic [DW-1:0]     s_rdata,
  input logic              s_ready,
  input logic              s_miss,
  input logic              m_req,
  input logic              m_we,
  input logic [IAW-1:0]    m_addr,
  input logic [DW-1:0]     m_wdata,
  input logic [DW-1:0]     m_rdata,
  input logic              m_ready
);
  // R7: request fields held until the internal side answers
  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ready) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata)));

  // R7: slave stalled while a forward is outstanding
  a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
    m_req |-> !s_ready);

  // R4: read data captured from the internal bus appears next cycle
  a_r4_rdata_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_ready && !m_we) |=> (s_ready && !s_miss && s_rdata == $past(m_rdata)));

  // R3: forwarded offset equals the low bits of the slave address
  a_r3_offset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_req) |-> (m_addr[OFS_W-1:0] == $past(s_addr[OFS_W-1:0])));

  // R6: a miss returns zero
  a_r6_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && s_miss) |-> (s_rdata == '0));

  // R8: completion is a single-cycle pulse
  a_r8_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> !s_ready);
endmodule

bind paged_reg_window win_checker #(
  .DW(DW), .CFG_AW(CFG_AW), .OFS_W(OFS_W), .IAW(IAW)
) u_win_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .s_addr  (s_addr),
  .s_rdata (s_rdata),
  .s_ready (s_ready),
  .s_miss  (s_miss),
  .m_req   (m_req),
  .m_we    (m_we),
  .m_addr  (m_addr),
  .m_wdata (m_wdata),
  .m_rdata (m_rdata),
  .m_ready (m_ready)
);

// File: tb/tb_paged_reg_window.sv
`timescale 1ns/1ps
module tb_paged_reg_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] s_addr = '0;
  logic [31:0] s_wdata = '0;
  logic        s_we = 1'b0;
  logic        s_re = 1'b0;
  logic [31:0] s_rdata;
  logic        s_ready;
  logic        s_miss;
  logic        m_req;
  logic        m_we;
  logic [31:0] m_addr;
  logic [31:0] m_wdata;
  logic [31:0] m_rdata = '0;
  logic        m_ready = 1'b0;

  int checks = 0;
  int errors = 0;

  int          lat_cfg = 0;
  int          wait_cnt = 0;
  int          fwd_cnt = 0;
  logic [31:0] log_addr = '0;
  logic        log_we = 1'b0;
  logic [31:0] log_wdata = '0;
  logic [22:0] page_m = '0;

  always #2.5 clk = ~clk;

  paged_reg_window dut (
    .clk(clk), .rst_n(rst_n),
    .s_addr(s_addr), .s_wdata(s_wdata), .s_we(s_we), .s_re(s_re),
    .s_rdata(s_rdata), .s_ready(s_ready), .s_miss(s_miss),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_ready(m_ready)
  );

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return a ^ 32'h5A5A_C3C3;
  endfunction

  // 0 miss, 1 page register, 2 window
  function automatic int exp_hit(input logic [11:0] a);
    if (a == 12'h41C) return 1;
    if (a >= 12'h800 && a <= 12'h9FF) return 2;
    return 0;
  endfunction

  // internal-side responder with programmable wait
  always @(negedge clk) begin
    if (m_req && !m_ready) begin
      if (wait_cnt >= lat_cfg) begin
        m_ready   <= 1'b1;
        m_rdata   <= mem_val(m_addr);
        log_addr  <= m_addr;
        log_we    <= m_we;
        log_wdata <= m_wdata;
        fwd_cnt   <= fwd_cnt + 1;
        wait_cnt  <= 0;
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end else begin
      m_ready  <= 1'b0;
      wait_cnt <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [11:0] a, input bit wr, input logic [31:0] wd,
                        input int lat, input string req);
    int cyc = 0;
    int fwd0;
    int h;
    logic [31:0] rd;
    logic        ms;
    h = exp_hit(a);
    @(negedge clk);
    lat_cfg = lat;
    fwd0    = fwd_cnt;
    s_addr  = a;
    s_wdata = wd;
    s_we    = wr;
    s_re    = !wr;
    do begin
      @(negedge clk);
      cyc++;
    end while (!s_ready && cyc < 50);
    rd = s_rdata;
    ms = s_miss;
    s_we = 1'b0;
    s_re = 1'b0;
    if (h == 2) begin
      chk(fwd_cnt == fwd0 + 1, req, "forward count", fwd_cnt, fwd0 + 1);
      chk(log_addr == {page_m, a[8:0]}, req, "internal address", log_addr, {page_m, a[8:0]});
      chk(log_we == wr, req, "internal write flag", log_we, wr);
      if (wr) chk(log_wdata == wd, req, "internal write data", log_wdata, wd);
      chk(rd == (wr ? 32'h0 : mem_val({page_m, a[8:0]})), req, "read data", rd,
          wr ? 32'h0 : mem_val({page_m, a[8:0]}));
      chk(ms == 1'b0, req, "miss flag", ms, 0);
      chk(cyc == 2 + lat, "R7", "window latency", cyc, 2 + lat);
    end else if (h == 1) begin
      chk(fwd_cnt == fwd0, req, "no forward on page access", fwd_cnt, fwd0);
      chk(rd == (wr ? 32'h0 : {9'h0, page_m}), req, "page read data", rd,
          wr ? 32'h0 : {9'h0, page_m});
      chk(ms == 1'b0, "R8", "miss flag on page hit", ms, 0);
      chk(cyc == 1, "R8", "page latency", cyc, 1);
      if (wr) page_m = wd[22:0];
    end else begin
      chk(fwd_cnt == fwd0, "R6", "no forward on miss", fwd_cnt, fwd0);
      chk(ms == 1'b1, "R6", "miss flag", ms, 1);
      chk(rd == 32'h0, "R6", "miss read data", rd, 0);
      chk(cyc == 1, "R8", "miss latency", cyc, 1);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk(m_req == 1'b0, "R1", "m_req after reset", m_req, 0);
    chk(s_ready == 1'b0, "R1", "s_ready after reset", s_ready, 0);
    access(12'h41C, 0, 0, 0, "R1");

    // R2: page write masks to 23 bits, reads back
    access(12'h41C, 1, 32'hFFFF_FFFF, 0, "R2");
    access(12'h41C, 0, 0, 0, "R2");
    access(12'h41C, 1, 32'h0012_3456, 0, "R2");
    access(12'h41C, 0, 0, 0, "R2");

    // R5: window edges with zero and long waits
    access(12'h800, 0, 0, 0, "R5");
    access(12'h9FC, 1, 32'hCAFE_0001, 3, "R5");
    access(12'h9FF, 0, 0, 2, "R5");
    access(12'h7FC, 0, 0, 0, "R5");
    access(12'hA00, 1, 32'h1, 0, "R5");

    // R6: miss write leaves page unchanged
    access(12'h41D, 1, 32'h0000_0777, 0, "R6");
    access(12'h41C, 0, 0, 0, "R6");

    // R3 / R4 / R9: page change between window accesses
    access(12'h810, 1, 32'hA5A5_0F0F, 1, "R3");
    access(12'h41C, 1, 32'h0000_0001, 0, "R9");
    access(12'h810, 0, 0, 0, "R9");
    access(12'h8F8, 0, 0, 3, "R4");

    // random mix
    for (int i = 0; i < 300; i++) begin
      int kind = $urandom_range(0, 9);
      int lat  = $urandom_range(0, 3);
      logic [31:0] wd = $urandom;
      bit wr = $urandom_range(0, 1) == 1;
      logic [11:0] a;
      if (kind < 2)      a = 12'h41C;
      else if (kind < 8) a = 12'h800 + 12'($urandom_range(0, 511));
      else               a = 12'($urandom);
      access(a, wr, wd, lat, (kind < 2) ? "R2" : (kind < 8) ? (wr ? "R3" : "R4") : "R6");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule